// File: doc/BRIEF.md
# Radio SPI Command Transaction Engine

This block is an SPI master that carries out one complete command exchange with a 2.4 GHz packet transceiver for each request it accepts. The requester gives a command kind, a five-bit register address, a byte count and up to 32 write bytes. The engine lowers chip select and shifts out a command byte built from the kind and the address. It then shifts out the data bytes, or dummy zeros when the command is a read. Chip select stays low until the last bit and then returns high. The byte clocked in during the command byte is the device status, and it is handed back together with every byte read.

A divider input sets the SCK half-period in system clock cycles. After each frame, chip select is held high for a minimum number of cycles before the engine will accept the next request. The block also registers a chip-enable level for the radio. It passes the active-low interrupt line through a two-stage synchronizer and reports it as an active-high level.

Command kind encoding on `req_kind`: 0 = register read, 1 = register write, 2 = receive-payload read, 3 = transmit-payload write.

Top module: `radio_spi_engine`

## Requirements
- R1: While reset is high, and immediately after it is released, `spi_cs_n` is 1 and `spi_sck`, `busy` and `done` are 0.
- R2: The command byte is `{3'b000, addr}` for a register read, `{3'b001, addr}` for a register write, 0x61 for a payload read and 0xA0 for a payload write.
- R3: Every byte is sent MSB first on `spi_mosi`. MOSI changes only while SCK is low. Each MISO bit is captured at the end of the SCK high phase and shifted into the LSB, so the first bit received becomes the MSB of the byte.
- R4: SCK is low whenever chip select is high.
- R5: Each SCK phase lasts `clk_div` clock cycles, and a value of 0 counts as 1. Chip select is low for exactly 16 × (bytes + 1) × half-period cycles. The divider value is sampled when the request is accepted.
- R6: `status_byte` holds the byte received while the command byte was being shifted out.
- R7: For read kinds (0 and 2), the engine shifts out 0x00 for each data byte. Data byte i received is stored at `rd_data[8i+7:8i]`.
- R8: For write kinds (1 and 3), data byte i is taken from `req_wdata[8i+7:8i]` and sent in order. The command and all of its data bytes go out within one chip-select low frame.
- R9: The byte count is clamped to 1..32 for payload kinds and to 1..5 for register kinds. A count of 0 becomes 1, and a count above the limit becomes the limit.
- R10: `busy` is 1 in the cycle after a request is accepted. A `req_valid` that arrives while `busy` is 1 starts no frame and changes no output.
- R11: `done` is a single-cycle pulse that occurs in exactly the cycle in which `spi_cs_n` rises.
- R12: After chip select rises, it stays high for at least GAP_CYC (default 4) cycles before the next frame, and `busy` stays 1 during that gap.
- R13: `radio_ce` follows `ce_req` one clock later. `irq_active` is the inverse of `irq_n`, delayed by two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, honoured only when idle |
| req_kind | input | 2 | Command kind (0 reg read, 1 reg write, 2 payload read, 3 payload write) |
| req_addr | input | 5 | Register address for kinds 0 and 1 |
| req_len | input | 6 | Requested data byte count (clamped) |
| req_wdata | input | 256 | Write bytes, byte i in bits 8i+7:8i |
| clk_div | input | 8 | SCK half-period in clock cycles |
| busy | output | 1 | Transaction or chip-select gap in progress |
| done | output | 1 | One-cycle pulse at end of frame |
| status_byte | output | 8 | Status byte captured during the command byte |
| rd_data | output | 256 | Read bytes, byte i in bits 8i+7:8i |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_miso | input | 1 | Serial data from the device |
| ce_req | input | 1 | Requested chip-enable level |
| radio_ce | output | 1 | Registered chip-enable to the radio |
| irq_n | input | 1 | Active-low interrupt from the device |
| irq_active | output | 1 | Synchronized, active-high interrupt level |

## Verification
Two things can happen in the same clock edge: the end of a frame (chip select rising together with the `done` pulse) and a new `req_valid` from the requester. The bench raises `req_valid` in exactly the cycle that `done` is high, and also in the middle of a frame. It then checks that no further chip-select frame or SCK activity follows, and that the next genuine request still gets its full frame and a gap of at least the minimum width. A scoreboard holds the expected MOSI bytes, the expected frame lengths, and the expected status and read bytes, computed from an independent device model.

// File: rtl/rspi_pkg.sv
package rspi_pkg;

    typedef enum logic [1:0] {
        CMD_REG_RD = 2'd0,
        CMD_REG_WR = 2'd1,
        CMD_PLD_RD = 2'd2,
        CMD_PLD_WR = 2'd3
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } eng_state_e;

    // Command byte: opcode with register address merged in for register kinds.
    function automatic logic [7:0] cmd_byte(cmd_kind_e kind, logic [4:0] addr);
        logic [7:0] b;
        case (kind)
            CMD_REG_RD: b = {3'b000, addr};
            CMD_REG_WR: b = {3'b001, addr};
            CMD_PLD_RD: b = 8'h61;
            default:    b = 8'hA0;
        endcase
        return b;
    endfunction

    function automatic logic kind_is_read(cmd_kind_e kind);
        return (kind == CMD_REG_RD) || (kind == CMD_PLD_RD);
    endfunction

    // Clamp a requested count into 1..limit, limit depending on kind.
    function automatic int unsigned clamp_len(cmd_kind_e kind, int unsigned len,
                                              int unsigned pld_max, int unsigned reg_max);
        int unsigned lim;
        lim = (kind == CMD_PLD_RD || kind == CMD_PLD_WR) ? pld_max : reg_max;
        if (len == 0)   return 1;
        if (len > lim)  return lim;
        return len;
    endfunction

endpackage

// File: rtl/rspi_tick.sv
module rspi_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = en && (cnt == half - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !en || tick) cnt <= '0;
        else                    cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/rspi_shifter.sv
module rspi_shifter (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       step,
    input  logic       miso,
    output logic       mosi,
    output logic [7:0] rx_byte
);
    logic [7:0] sh;

    assign mosi    = sh[7];
    assign rx_byte = {sh[6:0], miso};

    always_ff @(posedge clk) begin
        if (rst)       sh <= '0;
        else if (load) sh <= load_byte;
        else if (step) sh <= {sh[6:0], miso};
    end
endmodule

// File: rtl/rspi_sync.sv
module rspi_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] r;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) r <= {STAGES{RST_VAL}};
                else     r <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) r <= {STAGES{RST_VAL}};
                else     r <= {r[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = r[STAGES-1];
endmodule

// File: rtl/radio_spi_engine.sv
module radio_spi_engine
    import rspi_pkg::*;
#(
    parameter int MAX_BYTES = 32,
    parameter int REG_MAX   = 5,
    parameter int DIV_W     = 8,
    parameter int GAP_CYC   = 4,
    localparam int LEN_W    = $clog2(MAX_BYTES + 1),
    localparam int DATA_W   = MAX_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [4:0]        req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DIV_W-1:0]  clk_div,
    output logic              busy,
    output logic              done,
    output logic [7:0]        status_byte,
    output logic [DATA_W-1:0] rd_data,
    output logic              spi_sck,
    output logic              spi_mosi,
    output logic              spi_cs_n,
    input  logic              spi_miso,
    input  logic              ce_req,
    output logic              radio_ce,
    input  logic              irq_n,
    output logic              irq_active
);
    localparam int GCW = $clog2(GAP_CYC + 1);

    eng_state_e        state;
    cmd_kind_e         kind_q;
    logic [LEN_W-1:0]  nbytes_q;
    logic [LEN_W-1:0]  byte_idx;
    logic [2:0]        bit_idx;
    logic [DIV_W-1:0]  half_q;
    logic [DATA_W-1:0] wdata_q;
    logic [GCW-1:0]    gap_cnt;
    logic              sck_q, cs_n_q, busy_q, done_q;
    logic [7:0]        status_q;
    logic [DATA_W-1:0] rdata_q;

    logic              tick, accept, fall, byte_end, last_byte;
    logic              sh_load, sh_step;
    logic [7:0]        sh_byte, rx_byte, next_byte;
    logic              irq_sync;

    assign accept    = (state == ST_IDLE) && req_valid;
    assign fall      = (state == ST_SHIFT) && tick && sck_q;
    assign byte_end  = fall && (bit_idx == 3'd7);
    assign last_byte = (byte_idx == nbytes_q);

    always_comb begin
        next_byte = 8'h00;
        if (!kind_is_read(kind_q) && (int'(byte_idx) < MAX_BYTES))
            next_byte = wdata_q[int'(byte_idx)*8 +: 8];
    end

    assign sh_load = accept || (byte_end && !last_byte);
    assign sh_byte = accept ? cmd_byte(cmd_kind_e'(req_kind), req_addr) : next_byte;
    assign sh_step = fall && !sh_load;

    rspi_tick #(.DIV_W(DIV_W)) u_tick (
        .clk (clk),
        .rst (rst),
        .en  (state == ST_SHIFT),
        .half(half_q),
        .tick(tick)
    );

    rspi_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (sh_load),
        .load_byte(sh_byte),
        .step     (sh_step),
        .miso     (spi_miso),
        .mosi     (spi_mosi),
        .rx_byte  (rx_byte)
    );

    rspi_sync #(.STAGES(2), .RST_VAL(1'b1)) u_irq (
        .clk(clk),
        .rst(rst),
        .d  (irq_n),
        .q  (irq_sync)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            kind_q   <= CMD_REG_RD;
            nbytes_q <= LEN_W'(1);
            byte_idx <= '0;
            bit_idx  <= '0;
            half_q   <= DIV_W'(1);
            wdata_q  <= '0;
            gap_cnt  <= '0;
            sck_q    <= 1'b0;
            cs_n_q   <= 1'b1;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            status_q <= '0;
            rdata_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        kind_q   <= cmd_kind_e'(req_kind);
                        nbytes_q <= LEN_W'(clamp_len(cmd_kind_e'(req_kind), int'(req_len),
                                                     MAX_BYTES, REG_MAX));
                        half_q   <= (clk_div == '0) ? DIV_W'(1) : clk_div;
                        wdata_q  <= req_wdata;
                        byte_idx <= '0;
                        bit_idx  <= '0;
                        sck_q    <= 1'b0;
                        cs_n_q   <= 1'b0;
                        busy_q   <= 1'b1;
                        state    <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sck_q) begin
                            sck_q <= 1'b1;
                        end else begin
                            sck_q   <= 1'b0;
                            bit_idx <= bit_idx + 3'd1;
                            if (bit_idx == 3'd7) begin
                                if (byte_idx == '0)
                                    status_q <= rx_byte;
                                else if (kind_is_read(kind_q))
                                    rdata_q[(int'(byte_idx) - 1)*8 +: 8] <= rx_byte;
                                if (last_byte) begin
                                    cs_n_q  <= 1'b1;
                                    done_q  <= 1'b1;
                                    gap_cnt <= '0;
                                    state   <= ST_GAP;
                                end else begin
                                    byte_idx <= byte_idx + LEN_W'(1);
                                end
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (int'(gap_cnt) >= GAP_CYC - 1) begin
                        busy_q <= 1'b0;
                        state  <= ST_IDLE;
                    end else begin
                        gap_cnt <= gap_cnt + GCW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) radio_ce <= 1'b0;
        else     radio_ce <= ce_req;
    end

    assign irq_active  = ~irq_sync;
    assign busy        = busy_q;
    assign done        = done_q;
    assign status_byte = status_q;
    assign rd_data     = rdata_q;
    assign spi_sck     = sck_q;
    assign spi_cs_n    = cs_n_q;

    // Cycles chip select has been high, saturating; used by the gap check.
    logic [GCW-1:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (rst)                        hi_cnt <= GCW'(GAP_CYC);
        else if (!spi_cs_n)             hi_cnt <= '0;
        else if (int'(hi_cnt) < GAP_CYC) hi_cnt <= hi_cnt + GCW'(1);
    end

    a_r4_sck_idle_deselected: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

    a_r3_mosi_steady_high: assert property (@(posedge clk) disable iff (rst)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    a_r11_done_at_cs_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |-> done);

    a_r11_done_only_at_rise: assert property (@(posedge clk) disable iff (rst)
        done |-> $rose(spi_cs_n));

    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy);

    a_r12_cs_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> (int'(hi_cnt) >= GAP_CYC));

    a_r12_busy_in_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |-> busy);
endmodule

// File: tb/radio_spi_engine_test.sv
module radio_spi_engine_test;
    localparam int GAP = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid;
    logic [1:0]   req_kind;
    logic [4:0]   req_addr;
    logic [5:0]   req_len;
    logic [255:0] req_wdata;
    logic [7:0]   clk_div;
    logic         busy, done;
    logic [7:0]   status_byte;
    logic [255:0] rd_data;
    logic         sck, mosi, cs_n;
    logic         miso;
    logic         ce_req, radio_ce, irq_n, irq_active;

    always #2 clk = ~clk;

    radio_spi_engine uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .clk_div(clk_div), .busy(busy), .done(done), .status_byte(status_byte),
        .rd_data(rd_data), .spi_sck(sck), .spi_mosi(mosi), .spi_cs_n(cs_n),
        .spi_miso(miso), .ce_req(ce_req), .radio_ce(radio_ce), .irq_n(irq_n),
        .irq_active(irq_active)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int exp_frame = 0;
    int slv_frame = 0;

    typedef struct {
        logic [7:0]   st;
        int           n;
        bit           rd;
        logic [255:0] d;
    } exp_t;

    logic [7:0] q_mosi[$];
    int         q_cyc[$];
    exp_t       q_res[$];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] resp(input int f, input int k);
        int v;
        v = f * 37 + k * 11 + 60;
        return v[7:0];
    endfunction

    function automatic logic [7:0] exp_cmd(input logic [1:0] k, input logic [4:0] a);
        case (k)
            2'd0:    return {3'b000, a};
            2'd1:    return {3'b001, a};
            2'd2:    return 8'h61;
            default: return 8'hA0;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Device model: reacts at the falling clock edge to changes of the engine pins.
    logic       p_sck = 1'b0, p_cs = 1'b1;
    int         bitn = 0, bytek = 0, fall_cyc = 0, rise_cyc = -100;
    logic [7:0] txsh = 8'h00, rxsh = 8'h00;
    initial miso = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (p_cs && !cs_n) begin
                slv_frame++;
                chk(cyc - rise_cyc >= GAP, "R12 chip-select high gap", longint'(cyc - rise_cyc), GAP);
                fall_cyc = cyc; bitn = 0; bytek = 0;
                txsh = resp(slv_frame, 0);
                miso = txsh[7];
            end
            if (!p_sck && sck) begin
                rxsh = {rxsh[6:0], mosi};
                bitn++;
            end
            if (p_sck && !sck && bitn == 8) begin
                if (q_mosi.size() == 0) begin
                    chk(1'b0, "R10 unexpected MOSI byte", rxsh, 0);
                end else begin
                    logic [7:0] e;
                    e = q_mosi.pop_front();
                    chk(rxsh == e, "R2/R7/R8 MOSI byte", rxsh, e);
                end
                bitn = 0; bytek++;
                txsh = resp(slv_frame, bytek);
                miso = txsh[7];
            end else if (p_sck && !sck) begin
                txsh = {txsh[6:0], 1'b0};
                miso = txsh[7];
            end
            if (!p_cs && cs_n) begin
                rise_cyc = cyc;
                if (q_cyc.size() == 0) chk(1'b0, "R10 unexpected frame", 1, 0);
                else begin
                    int e;
                    e = q_cyc.pop_front();
                    chk(cyc - fall_cyc == e, "R5/R9 frame length", longint'(cyc - fall_cyc), e);
                end
            end
        end
        p_sck = sck;
        p_cs  = cs_n;
    end

    // Monitor: compares results when done pulses.
    always @(negedge clk) begin
        if (!rst && done) begin
            chk(cs_n === 1'b1, "R11 done with chip select high", cs_n, 1);
            if (q_res.size() == 0) chk(1'b0, "R11 unexpected done", 1, 0);
            else begin
                exp_t e;
                e = q_res.pop_front();
                chk(status_byte == e.st, "R6 status byte", status_byte, e.st);
                if (e.rd)
                    for (int i = 0; i < e.n; i++)
                        chk(rd_data[i*8 +: 8] == e.d[i*8 +: 8], "R7 read byte",
                            rd_data[i*8 +: 8], e.d[i*8 +: 8]);
            end
        end
    end

    task automatic run(input logic [1:0] k, input logic [4:0] a, input int len,
                       input int div, input logic [255:0] wd, input bit spurious,
                       input bit poke_done);
        int n, h, lim;
        exp_t e;
        lim = (k >= 2'd2) ? 32 : 5;
        n = (len == 0) ? 1 : ((len > lim) ? lim : len);
        h = (div == 0) ? 1 : div;
        exp_frame++;
        q_mosi.push_back(exp_cmd(k, a));
        for (int i = 0; i < n; i++)
            q_mosi.push_back((k == 2'd0 || k == 2'd2) ? 8'h00 : wd[i*8 +: 8]);
        q_cyc.push_back(16 * (n + 1) * h);
        e.st = resp(exp_frame, 0);
        e.n  = n;
        e.rd = (k == 2'd0 || k == 2'd2);
        e.d  = '0;
        for (int i = 0; i < n; i++) e.d[i*8 +: 8] = resp(exp_frame, i + 1);
        q_res.push_back(e);

        while (busy) @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a;
        req_len = 6'(len); clk_div = 8'(div); req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy === 1'b1, "R10 busy after accept", busy, 1);
        if (spurious) begin
            repeat (3) @(negedge clk);
            req_valid = 1'b1; req_kind = 2'd3; req_len = 6'd1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        if (poke_done) begin
            req_valid = 1'b1; req_kind = 2'd2; req_len = 6'd2;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(done === 1'b0, "R11 done lasts one cycle", done, 0);
        chk(busy === 1'b1, "R12 busy during gap", busy, 1);
    endtask

    initial begin
        logic [255:0] wd;
        for (int i = 0; i < 32; i++) wd[i*8 +: 8] = 8'(i * 7 + 3);
        rst = 1'b1; req_valid = 1'b0; req_kind = 2'd0; req_addr = 5'd0;
        req_len = 6'd0; req_wdata = '0; clk_div = 8'd1; ce_req = 1'b0; irq_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(cs_n === 1'b1 && sck === 1'b0, "R1 pins in reset", {cs_n, sck}, 2'b10);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R1 busy/done after reset", {busy, done}, 0);
        chk(cs_n === 1'b1, "R1 chip select after reset", cs_n, 1);

        // R13: chip enable and interrupt level
        ce_req = 1'b1; irq_n = 1'b0;
        @(negedge clk);
        chk(radio_ce === 1'b1, "R13 ce one cycle", radio_ce, 1);
        chk(irq_active === 1'b0, "R13 irq not yet", irq_active, 0);
        @(negedge clk);
        chk(irq_active === 1'b1, "R13 irq after two", irq_active, 1);
        irq_n = 1'b1; ce_req = 1'b0;
        repeat (2) @(negedge clk);
        chk(irq_active === 1'b0 && radio_ce === 1'b0, "R13 deassert", {irq_active, radio_ce}, 0);

        run(2'd1, 5'h05, 1, 1, wd, 1'b0, 1'b0);        // R2 register write
        run(2'd0, 5'h07, 1, 2, wd, 1'b0, 1'b0);        // R6 R7 register read
        run(2'd1, 5'h10, 3, 3, wd, 1'b0, 1'b0);        // R8 three-byte burst
        run(2'd1, 5'h0A, 5, 1, wd, 1'b1, 1'b0);        // R10 request mid-frame
        run(2'd0, 5'h1F, 0, 1, wd, 1'b0, 1'b0);        // R9 zero count
        run(2'd1, 5'h11, 9, 1, wd, 1'b0, 1'b0);        // R9 register clamp to 5
        run(2'd3, 5'h00, 32, 1, wd, 1'b0, 1'b0);       // R8 full payload write
        run(2'd2, 5'h00, 4, 2, wd, 1'b0, 1'b0);        // R7 payload read
        run(2'd2, 5'h00, 40, 1, wd, 1'b0, 1'b0);       // R9 payload clamp to 32
        run(2'd3, 5'h00, 0, 0, wd, 1'b0, 1'b1);        // R5 div 0, R10 poke at done
        repeat (30) @(negedge clk);
        chk(slv_frame == exp_frame, "R10 no frame from ignored request", slv_frame, exp_frame);
        chk(cs_n === 1'b1 && busy === 1'b0, "R10 idle after ignored request", {cs_n, busy}, 2'b10);
        run(2'd0, 5'h03, 2, 4, wd, 1'b0, 1'b0);        // R3 R5 slow divider
        repeat (10) @(negedge clk);
        chk(q_mosi.size() == 0 && q_res.size() == 0, "R8 scoreboard drained",
            q_mosi.size() + q_res.size(), 0);
        chk(slv_frame == exp_frame, "R8 one frame per request", slv_frame, exp_frame);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule